// File: doc/BRIEF.md
# RGB LED Strip Driver

This block drives a chain of addressable RGB LEDs over a two-wire serial link made of a clock and a data line. A host writes 7-bit colour values one at a time through a parallel write port. The address of each write names one LED and one of its colour channels. The block keeps every value in an internal register file. At a programmable interval it streams the whole chain out, then sends trailing zero bytes so that the strip latches the frame.

For each LED, three bytes go out: green, then red, then blue. LED 0 comes first. Every byte carries a set top bit followed by the 7-bit colour, most significant bit first. The serial clock comes from the system clock through a parameterised divider. Data changes only while that clock is low, and the strip samples it on the rising edge. A host may write at any time, including during a frame. A changed channel shows on the strip the next time that channel is shifted out.

Top module: `rgb_strip_drv`

## Requirements
- R1: After reset, `sclk_o` and `sdata_o` are low and every stored colour is zero, so the first frame sends 0x80 for every channel.
- R2: The first frame's first serial clock rise comes one refresh interval (`REFRESH_CYCLES` system cycles, within a few cycles of pipeline delay) after reset release. Before that, the serial clock stays low.
- R3: Each colour byte is sent most significant bit first as {1, colour[6:0]}.
- R4: `wr_addr_i[1:0]` selects the channel: 0 for green, 1 for red, 2 for blue. `wr_addr_i[ADDR_W-1:2]` selects the LED index. A frame sends LED 0 to LED NUM_LEDS-1 in order, each as green, red, blue.
- R5: A write with channel code 3, or with an LED index of NUM_LEDS or more, changes no stored colour.
- R6: After the last blue byte, the frame ends with ceil(NUM_LEDS/32) all-zero bytes.
- R7: `sdata_o` never changes while `sclk_o` is high. Within a byte, consecutive rising edges of `sclk_o` are 2*HALF_DIV system cycles apart.
- R8: Frame starts are REFRESH_CYCLES apart when a frame fits in the interval. A new frame never starts before the previous frame, including its zero bytes, has finished.
- R9: A write during a frame takes effect in that frame if its channel has not yet been shifted out. Otherwise it takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Colour write strobe |
| wr_addr_i | input | ADDR_W | {LED index, channel code} |
| wr_data_i | input | 7 | Colour value |
| sclk_o | output | 1 | Serial clock to strip |
| sdata_o | output | 1 | Serial data to strip |

## Verification
The bench builds two instances, both with a divider half-period of 2 cycles and a 1000-cycle refresh interval. The first drives five LEDs. With five LEDs, three LED indices are unused, so out-of-range writes can be tried, and a whole frame of about 530 cycles fits inside one interval, which makes the exact start spacing measurable. The second drives 33 LEDs. That count crosses the 32-LED boundary, so the frame carries two latch bytes, and the frame is longer than the interval, so back-to-back starts gated by frame completion are exercised.

// File: rtl/rgb_strip_pkg.sv
package rgb_strip_pkg;
  localparam int COLOR_W = 7;

  typedef enum logic [1:0] {
    CH_GREEN = 2'd0,
    CH_RED   = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_SEND  = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/rgb_color_store.sv
module rgb_color_store
  import rgb_strip_pkg::*;
#(
  parameter int NUM_LEDS = 8,
  parameter int LED_W    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [LED_W-1:0]   wr_led_i,
  input  logic [1:0]         wr_ch_i,
  input  logic [COLOR_W-1:0] wr_val_i,
  input  logic [LED_W-1:0]   rd_led_i,
  input  logic [1:0]         rd_ch_i,
  output logic [COLOR_W-1:0] rd_val_o
);
  localparam int ENTRIES = NUM_LEDS * 3;
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][COLOR_W-1:0] mem_q;
  logic                            wr_ok;
  int                              wr_idx;
  logic [IDX_W-1:0]                rd_idx;

  assign wr_ok  = wr_en_i && (wr_ch_i != 2'd3) && (int'(wr_led_i) < NUM_LEDS);
  assign wr_idx = int'(wr_led_i) * 3 + int'(wr_ch_i);
  assign rd_idx = IDX_W'(int'(rd_led_i) * 3 + int'(rd_ch_i));

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [COLOR_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      ent_q <= '0;
      else if (wr_ok && wr_idx == e)    ent_q <= wr_val_i;
    end
    assign mem_q[e] = ent_q;
  end

  assign rd_val_o = mem_q[rd_idx];

  // R5
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_ch_i == 2'd3 || int'(wr_led_i) >= NUM_LEDS)) |=> $stable(mem_q));
endmodule

// File: rtl/rgb_bit_shifter.sv
module rgb_bit_shifter #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       ready_o,
  output logic       sclk_o,
  output logic       sdata_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             busy_q, sclk_q, sdata_q;
  logic [7:0]       sh_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sclk_q  <= 1'b0;
      sdata_q <= 1'b0;
      sh_q    <= '0;
      bit_q   <= '0;
      div_q   <= '0;
    end else if (load_i && !busy_q) begin
      busy_q  <= 1'b1;
      sh_q    <= byte_i;
      sdata_q <= byte_i[7];
      sclk_q  <= 1'b0;
      bit_q   <= '0;
      div_q   <= '0;
    end else if (busy_q) begin
      if (div_q == DIV_W'(HALF_DIV - 1)) begin
        div_q <= '0;
        if (!sclk_q) begin
          sclk_q <= 1'b1;
        end else begin
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            busy_q  <= 1'b0;
            sdata_q <= 1'b0;
          end else begin
            bit_q   <= bit_q + 3'd1;
            sh_q    <= {sh_q[6:0], 1'b0};
            sdata_q <= sh_q[6];
          end
        end
      end else begin
        div_q <= div_q + DIV_W'(1);
      end
    end
  end

  assign ready_o = !busy_q;
  assign sclk_o  = sclk_q;
  assign sdata_o = sdata_q;

  // R7
  data_stable_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(sdata_q));

  // R8
  no_load_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
endmodule

// File: rtl/rgb_frame_seq.sv
module rgb_frame_seq
  import rgb_strip_pkg::*;
#(
  parameter int NUM_LEDS       = 8,
  parameter int LED_W          = 3,
  parameter int REFRESH_CYCLES = 100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sh_ready_i,
  input  logic [COLOR_W-1:0] rd_val_i,
  output logic [LED_W-1:0]   rd_led_o,
  output logic [1:0]         rd_ch_o,
  output logic               load_o,
  output logic [7:0]         byte_o,
  output logic               latch_o,
  output logic               active_o
);
  localparam int LATCH_N = (NUM_LEDS + 31) / 32;
  localparam int LAT_W   = (LATCH_N > 1) ? $clog2(LATCH_N) : 1;
  localparam int TMR_W   = $clog2(REFRESH_CYCLES + 1);

  seq_state_e       state_q;
  logic [LED_W-1:0] led_q;
  logic [1:0]       ch_q;
  logic             latch_q;
  logic [LAT_W-1:0] lat_q;
  logic [TMR_W-1:0] tmr_q;
  logic             elapsed, start;

  assign elapsed = (tmr_q == TMR_W'(REFRESH_CYCLES - 1));
  assign start   = (state_q == SEQ_IDLE) && elapsed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        tmr_q <= '0;
    else if (start)     tmr_q <= '0;
    else if (!elapsed)  tmr_q <= tmr_q + TMR_W'(1);
  end

  assign load_o = (state_q == SEQ_SEND) && sh_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      led_q   <= '0;
      ch_q    <= '0;
      latch_q <= 1'b0;
      lat_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start) begin
          state_q <= SEQ_SEND;
          led_q   <= '0;
          ch_q    <= CH_GREEN;
          latch_q <= 1'b0;
          lat_q   <= '0;
        end
        SEQ_SEND: if (sh_ready_i) begin
          if (!latch_q) begin
            if (ch_q == CH_BLUE) begin
              ch_q <= CH_GREEN;
              if (led_q == LED_W'(NUM_LEDS - 1)) latch_q <= 1'b1;
              else                               led_q   <= led_q + LED_W'(1);
            end else begin
              ch_q <= ch_q + 2'd1;
            end
          end else if (lat_q == LAT_W'(LATCH_N - 1)) begin
            state_q <= SEQ_DRAIN;
          end else begin
            lat_q <= lat_q + LAT_W'(1);
          end
        end
        SEQ_DRAIN: if (sh_ready_i) state_q <= SEQ_IDLE;
        default:   state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign rd_led_o = led_q;
  assign rd_ch_o  = ch_q;
  assign byte_o   = latch_q ? 8'h00 : {1'b1, rd_val_i};
  assign latch_o  = latch_q;
  assign active_o = (state_q != SEQ_IDLE);
endmodule

// File: rtl/rgb_strip_drv.sv
module rgb_strip_drv
  import rgb_strip_pkg::*;
#(
  parameter  int NUM_LEDS       = 8,
  parameter  int HALF_DIV       = 4,
  parameter  int REFRESH_CYCLES = 100000,
  localparam int LED_W          = (NUM_LEDS > 1) ? $clog2(NUM_LEDS) : 1,
  localparam int ADDR_W         = LED_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [6:0]        wr_data_i,
  output logic              sclk_o,
  output logic              sdata_o
);
  logic [LED_W-1:0]   rd_led;
  logic [1:0]         rd_ch;
  logic [COLOR_W-1:0] rd_val;
  logic               sh_load, sh_ready, seq_latch, seq_active;
  logic [7:0]         sh_byte;

  rgb_color_store #(.NUM_LEDS(NUM_LEDS), .LED_W(LED_W)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i,
    .wr_led_i (wr_addr_i[ADDR_W-1:2]),
    .wr_ch_i  (wr_addr_i[1:0]),
    .wr_val_i (wr_data_i),
    .rd_led_i (rd_led),
    .rd_ch_i  (rd_ch),
    .rd_val_o (rd_val)
  );

  rgb_frame_seq #(.NUM_LEDS(NUM_LEDS), .LED_W(LED_W),
                  .REFRESH_CYCLES(REFRESH_CYCLES)) u_seq (
    .clk_i, .rst_ni,
    .sh_ready_i (sh_ready),
    .rd_val_i   (rd_val),
    .rd_led_o   (rd_led),
    .rd_ch_o    (rd_ch),
    .load_o     (sh_load),
    .byte_o     (sh_byte),
    .latch_o    (seq_latch),
    .active_o   (seq_active)
  );

  rgb_bit_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk_i, .rst_ni,
    .load_i  (sh_load),
    .byte_i  (sh_byte),
    .ready_o (sh_ready),
    .sclk_o,
    .sdata_o
  );

  // R3
  color_msb_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_load && !seq_latch) |-> sh_byte[7]);

  // R8
  shift_within_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sh_ready |-> seq_active);
endmodule

// File: tb/rgb_strip_drv_tb_top.sv
module rgb_strip_mon (
  input logic clk_i,
  input logic sclk_i,
  input logic sdata_i,
  input int   cyc_i
);
  int         frame_cnt = 0;
  logic [7:0] cur_q  [128];
  logic [7:0] last_q [128];
  int cur_n = 0, last_n = 0, zc = 0, last_z = 0;
  int start_cur = 0, start_prev = 0, first_start = -1;
  int rise_prev = 0, byte_t = 0, gap_min = 1 << 30, gap_max = 0, glitch = 0;
  int   nbits = 0;
  logic [7:0] bits = '0;
  logic prev_sclk = 1'b0, sd_prev = 1'b0, seen_zero = 1'b1;

  always @(negedge clk_i) begin
    logic [7:0] b;
    if (sclk_i && prev_sclk && sdata_i != sd_prev) glitch++;
    if (sclk_i && !prev_sclk) begin
      if (nbits != 0) begin
        if (cyc_i - rise_prev < gap_min) gap_min = cyc_i - rise_prev;
        if (cyc_i - rise_prev > gap_max) gap_max = cyc_i - rise_prev;
      end else begin
        byte_t = cyc_i;
      end
      rise_prev = cyc_i;
      b = {bits[6:0], sdata_i};
      bits = b;
      nbits++;
      if (nbits == 8) begin
        nbits = 0;
        if (b[7] && seen_zero) begin
          if (frame_cnt > 0) begin
            for (int k = 0; k < 128; k++) last_q[k] = cur_q[k];
            last_n = cur_n;
            last_z = zc;
          end
          start_prev = start_cur;
          start_cur  = byte_t;
          if (frame_cnt == 0) first_start = byte_t;
          frame_cnt++;
          cur_n = 0; zc = 0; seen_zero = 1'b0;
        end
        if (b == 8'h00) begin
          zc++;
          seen_zero = 1'b1;
        end else if (cur_n < 128) begin
          cur_q[cur_n] = b;
          cur_n++;
        end
      end
    end
    prev_sclk = sclk_i;
    sd_prev   = sdata_i;
  end
endmodule

module rgb_strip_drv_tb_top;
  localparam int NL   = 5;
  localparam int HD   = 2;
  localparam int RC   = 1000;
  localparam int AW   = 5;
  localparam int AW33 = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [6:0] wr_data = '0;
  logic sclk, sdata, sclk33, sdata33;
  int cyc = 0, n_chk = 0, n_err = 0;
  int exp_v [NL][3];

  always #2.5 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  rgb_strip_drv #(.NUM_LEDS(NL), .HALF_DIV(HD), .REFRESH_CYCLES(RC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sclk_o(sclk), .sdata_o(sdata));

  rgb_strip_drv #(.NUM_LEDS(33), .HALF_DIV(HD), .REFRESH_CYCLES(RC)) dut33_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(1'b0), .wr_addr_i(AW33'(0)),
    .wr_data_i(7'd0), .sclk_o(sclk33), .sdata_o(sdata33));

  rgb_strip_mon mon_i   (.clk_i(clk), .sclk_i(sclk),   .sdata_i(sdata),   .cyc_i(cyc));
  rgb_strip_mon mon33_i (.clk_i(clk), .sclk_i(sclk33), .sdata_i(sdata33), .cyc_i(cyc));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int led, input int ch, input int val);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(led * 4 + ch); wr_data = 7'(val);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    int target = mon_i.frame_cnt + n;
    while (mon_i.frame_cnt < target) @(negedge clk);
  endtask

  task automatic check_frame(input string req);
    chk(mon_i.last_n == NL * 3, req, mon_i.last_n, NL * 3);
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < 3; c++)
        chk(mon_i.last_q[l*3+c] == {1'b1, 7'(exp_v[l][c])}, req,
            int'(mon_i.last_q[l*3+c]), 128 + exp_v[l][c]);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(sclk == 1'b0, "R1 sclk low", int'(sclk), 0);
    chk(sdata == 1'b0, "R1 sdata low", int'(sdata), 0);
    while (cyc < RC - 20) @(negedge clk);
    chk(mon_i.frame_cnt == 0 && mon_i.gap_max == 0, "R2 quiet before interval",
        mon_i.frame_cnt, 0);
    wait_frames(2);
    chk(mon_i.first_start >= RC - 2 && mon_i.first_start <= RC + 10,
        "R2 first frame time", mon_i.first_start, RC);
    for (int l = 0; l < NL; l++) for (int c = 0; c < 3; c++) exp_v[l][c] = 0;
    check_frame("R1 R3 zero colours");
    chk(mon_i.last_z == 1, "R6 latch bytes n=5", mon_i.last_z, 1);
    chk(mon_i.gap_min == 2 * HD, "R7 rise spacing min", mon_i.gap_min, 2 * HD);
    chk(mon_i.gap_max == 2 * HD, "R7 rise spacing max", mon_i.gap_max, 2 * HD);
  endtask

  task automatic t_pattern;
    for (int l = 0; l < NL; l++)
      for (int c = 0; c < 3; c++) begin
        exp_v[l][c] = ((l * 3 + c) * 37 + 5) & 7'h7f;
        wr(l, c, exp_v[l][c]);
      end
    exp_v[2][1] = 7'h7f; wr(2, 1, 7'h7f);
    exp_v[3][2] = 0;     wr(3, 2, 0);
    wait_frames(2);
    check_frame("R3 R4 pattern order");
    chk(mon_i.start_cur - mon_i.start_prev == RC, "R8 start spacing",
        mon_i.start_cur - mon_i.start_prev, RC);
  endtask

  task automatic t_ignored;
    wr(1, 3, 7'h55);
    wr(5, 0, 7'h11);
    wr(7, 2, 7'h22);
    wr(6, 1, 7'h33);
    wait_frames(2);
    check_frame("R5 ignored writes");
  endtask

  task automatic t_midframe;
    int old_g0;
    wait_frames(1);
    old_g0 = exp_v[0][0];
    wr(0, 0, 7'h0a);
    wr(4, 2, 7'h6b);
    exp_v[4][2] = 7'h6b;
    wait_frames(1);
    exp_v[0][0] = old_g0;
    check_frame("R9 late channel same frame");
    exp_v[0][0] = 7'h0a;
    wait_frames(1);
    check_frame("R9 early channel next frame");
  endtask

  task automatic t_long;
    while (mon33_i.frame_cnt < 3) @(negedge clk);
    chk(mon33_i.last_z == 2, "R6 latch bytes n=33", mon33_i.last_z, 2);
    chk(mon33_i.last_n == 99, "R4 byte count n=33", mon33_i.last_n, 99);
    chk(mon33_i.start_cur - mon33_i.start_prev >= 101 * 32 &&
        mon33_i.start_cur - mon33_i.start_prev <= 3400,
        "R8 frame gates refresh", mon33_i.start_cur - mon33_i.start_prev, 3335);
    chk(mon_i.glitch == 0 && mon33_i.glitch == 0, "R7 data stable while high",
        mon_i.glitch + mon33_i.glitch, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pattern();
    t_ignored();
    t_midframe();
    t_long();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule